// File: doc/BRIEF.md
# Chipset power mode controller

This controller sequences a host bridge or memory controller through five power modes: full-on, doze, nap, sleep and suspend. Software sets mode-request bits together with a global power-management enable. The controller enters the requested mode from full-on. Nap and sleep may wait for a quiesce request from the processor. A processor-side acknowledge then reports that the bridge has gone quiet.

Bus requests, NMI and, in the lighter modes, a PCI address hit wake the controller back to full-on. A hard reset always forces full-on. A processor-type input inverts the sense of the quiesce request and acknowledge pins, so that processors which signal halt/run with the opposite levels can connect directly. A mode input lets nap and sleep be entered without waiting for the quiesce request at all.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While `hard_rst` is high at a rising clock edge, the mode after that edge is full-on (`mode` = 0) and `qack` is deasserted. This overrides every other input, including an asserted suspend.
- R2: In full-on, with `pm_en` = 1, only `doze_req` set and `suspend_n` = 1, the next mode is doze (`mode` = 1). This does not depend on `qreq`.
- R3: With `need_qreq` = 1, nap (`mode` = 2) and sleep (`mode` = 3) are entered only when the quiesce request is asserted. Otherwise the controller stays in full-on.
- R4: With `need_qreq` = 0, nap and sleep are entered on the first edge at which their request bit and `pm_en` are set, whatever the level of `qreq`.
- R5: Sleep outranks nap, and nap outranks doze. If a higher-ranked request is set but cannot proceed, no lower mode is taken. Request bits are acted on only in full-on and only when `pm_en` = 1.
- R6: Doze and nap return to full-on after any `bus_req_n` line is low, `pci_hit` is high, or `nmi` is high at a clock edge.
- R7: Sleep returns to full-on after any `bus_req_n` line is low or `nmi` is high. A `pci_hit` leaves it in sleep.
- R8: From full-on, `suspend_n` = 0 with `pm_en` = 1 enters suspend (`mode` = 4). Suspend entry has priority over the request bits. Suspend ignores request bits and wake events, and returns to full-on once `suspend_n` is 1.
- R9: `qack` is asserted exactly while the mode is nap or sleep. The asserted level is low when `proc_alt` = 0 and high when `proc_alt` = 1.
- R10: The quiesce request on `qreq` counts as asserted when it is low with `proc_alt` = 0, and when it is high with `proc_alt` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| pm_en | input | 1 | Global power-management enable |
| doze_req | input | 1 | Doze request bit |
| nap_req | input | 1 | Nap request bit |
| sleep_req | input | 1 | Sleep request bit |
| need_qreq | input | 1 | 1: nap and sleep wait for the quiesce request |
| proc_alt | input | 1 | Selects inverted quiesce handshake levels |
| qreq | input | 1 | Quiesce request pin from the processor |
| suspend_n | input | 1 | Suspend request, active low |
| bus_req_n | input | NUM_BUS_REQ | Processor bus request lines, active low |
| pci_hit | input | 1 | PCI address hit wake event |
| nmi | input | 1 | Non-maskable interrupt wake event |
| qack | output | 1 | Quiesce acknowledge pin to the processor |
| mode | output | 3 | Current mode: 0 full-on, 1 doze, 2 nap, 3 sleep, 4 suspend |

## Verification
The hardest cases to reach from the ports are those where the design must not move. Examples are a PCI hit that arrives while the controller is already in sleep, and request bits that change while it sits in nap or suspend. The stimulus table first walks the controller into each mode and then applies the event that should be ignored in the following row. For a few cases it applies the ignored event together with the request bits that would move it in full-on. The alternate handshake polarity is reached by flipping `proc_alt` between rows while holding `qreq` fixed. This shows that the same pin level is treated as asserted in one setting and as idle in the other.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      PM_FULL_ON = 3'd0,
      PM_DOZE    = 3'd1,
      PM_NAP     = 3'd2,
      PM_SLEEP   = 3'd3,
      PM_SUSPEND = 3'd4
   } pm_mode_e;
endpackage

// File: rtl/pwr_hs_if.sv
// Quiesce handshake pin adaptation: normalises the request sense and
// drives the acknowledge level for the selected processor type.
module pwr_hs_if #(
   parameter bit ALT_PROC_SUPPORT = 1'b1
) (
   input  logic proc_alt,
   input  logic qreq_pin,
   input  logic deep_mode,
   output logic qreq_act,
   output logic qack_pin
);
   generate
      if (ALT_PROC_SUPPORT) begin : g_selectable
         // alternate processor: request high = asserted, ack high = asserted
         assign qreq_act = proc_alt ? qreq_pin : ~qreq_pin;
         assign qack_pin = proc_alt ? deep_mode : ~deep_mode;
      end else begin : g_fixed_low
         logic unused_alt;
         assign unused_alt = proc_alt;
         assign qreq_act   = ~qreq_pin;
         assign qack_pin   = ~deep_mode;
      end
   endgenerate
endmodule

// File: rtl/pwr_wake_det.sv
// Wake event aggregation; the deep set excludes the PCI address hit.
module pwr_wake_det #(
   parameter int NUM_BUS_REQ = 2
) (
   input  logic [NUM_BUS_REQ-1:0] bus_req_n,
   input  logic                   pci_hit,
   input  logic                   nmi,
   output logic                   wake_light,
   output logic                   wake_deep
);
   generate
      if (NUM_BUS_REQ < 1) begin : g_bad_width
         $error("pwr_wake_det: NUM_BUS_REQ must be at least 1");
      end
   endgenerate

   logic any_bus_req;
   assign any_bus_req = ~(&bus_req_n);
   assign wake_deep   = any_bus_req | nmi;
   assign wake_light  = wake_deep | pci_hit;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic     clk,
   input  logic     hard_rst,
   input  logic     pm_en,
   input  logic     doze_req,
   input  logic     nap_req,
   input  logic     sleep_req,
   input  logic     need_qreq,
   input  logic     qreq_act,
   input  logic     suspend_n,
   input  logic     wake_light,
   input  logic     wake_deep,
   input  logic     pci_hit,
   output pm_mode_e state
);
   pm_mode_e nxt;
   logic     hs_ok;

   assign hs_ok = ~need_qreq | qreq_act;

   always_comb begin
      nxt = state;
      case (state)
         PM_FULL_ON: begin
            if (pm_en && !suspend_n) begin
               nxt = PM_SUSPEND;
            end else if (pm_en) begin
               if (sleep_req) begin
                  if (hs_ok) nxt = PM_SLEEP;
               end else if (nap_req) begin
                  if (hs_ok) nxt = PM_NAP;
               end else if (doze_req) begin
                  nxt = PM_DOZE;
               end
            end
         end
         PM_DOZE, PM_NAP: if (wake_light) nxt = PM_FULL_ON;
         PM_SLEEP:        if (wake_deep)  nxt = PM_FULL_ON;
         PM_SUSPEND:      if (suspend_n)  nxt = PM_FULL_ON;
         default:         nxt = PM_FULL_ON;
      endcase
   end

   always_ff @(posedge clk) begin
      if (hard_rst) state <= PM_FULL_ON;
      else          state <= nxt;
   end

   AST_HARD_RST_FULL_ON: assert property (@(posedge clk)
      hard_rst |=> state == PM_FULL_ON);  // R1

   AST_DOZE_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (hard_rst)
      (state == PM_FULL_ON && pm_en && suspend_n && doze_req && !nap_req && !sleep_req)
      |=> state == PM_DOZE);  // R2

   AST_DEEP_WAITS_QREQ: assert property (@(posedge clk) disable iff (hard_rst)
      (state == PM_FULL_ON && need_qreq && !qreq_act)
      |=> (state != PM_NAP && state != PM_SLEEP));  // R3

   AST_ENTRY_FROM_FULL_ON: assert property (@(posedge clk) disable iff (hard_rst)
      (!$stable(state) && state != PM_FULL_ON) |-> $past(state) == PM_FULL_ON);  // R5

   AST_SLEEP_IGNORES_PCI: assert property (@(posedge clk) disable iff (hard_rst)
      (state == PM_SLEEP && pci_hit && !wake_deep) |=> state == PM_SLEEP);  // R7

   AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (hard_rst)
      (state == PM_SUSPEND && !suspend_n) |=> state == PM_SUSPEND);  // R8
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pwr_mode_pkg::*;
#(
   parameter int NUM_BUS_REQ      = 2,
   parameter bit ALT_PROC_SUPPORT = 1'b1
) (
   input  logic                   clk,
   input  logic                   hard_rst,
   input  logic                   pm_en,
   input  logic                   doze_req,
   input  logic                   nap_req,
   input  logic                   sleep_req,
   input  logic                   need_qreq,
   input  logic                   proc_alt,
   input  logic                   qreq,
   input  logic                   suspend_n,
   input  logic [NUM_BUS_REQ-1:0] bus_req_n,
   input  logic                   pci_hit,
   input  logic                   nmi,
   output logic                   qack,
   output logic [MODE_W-1:0]      mode
);
   pm_mode_e state;
   logic     qreq_act, wake_light, wake_deep, deep_mode;

   assign deep_mode = (state == PM_NAP) || (state == PM_SLEEP);
   assign mode      = state;

   pwr_hs_if #(.ALT_PROC_SUPPORT(ALT_PROC_SUPPORT)) u_hs (
      .proc_alt  (proc_alt),
      .qreq_pin  (qreq),
      .deep_mode (deep_mode),
      .qreq_act  (qreq_act),
      .qack_pin  (qack)
   );

   pwr_wake_det #(.NUM_BUS_REQ(NUM_BUS_REQ)) u_wake (
      .bus_req_n  (bus_req_n),
      .pci_hit    (pci_hit),
      .nmi        (nmi),
      .wake_light (wake_light),
      .wake_deep  (wake_deep)
   );

   pwr_mode_fsm u_fsm (
      .clk        (clk),
      .hard_rst   (hard_rst),
      .pm_en      (pm_en),
      .doze_req   (doze_req),
      .nap_req    (nap_req),
      .sleep_req  (sleep_req),
      .need_qreq  (need_qreq),
      .qreq_act   (qreq_act),
      .suspend_n  (suspend_n),
      .wake_light (wake_light),
      .wake_deep  (wake_deep),
      .pci_hit    (pci_hit),
      .state      (state)
   );

   AST_QACK_IDLE_IN_FULL_ON: assert property (@(posedge clk) disable iff (hard_rst)
      (mode == 3'd0) |-> (qack == !(proc_alt && ALT_PROC_SUPPORT)));  // R9

   AST_WAKE_SETS_NEST: assert property (@(posedge clk)
      wake_deep |-> wake_light);  // R6
endmodule

// File: tb/pwr_mode_ctl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctl_bench;
   localparam int NB = 2;
   localparam int NV = 22;

   logic clk = 1'b0;
   logic hard_rst, pm_en, doze_req, nap_req, sleep_req, need_qreq;
   logic proc_alt, qreq, suspend_n, pci_hit, nmi, qack;
   logic [NB-1:0] bus_req_n;
   logic [2:0] mode;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   pwr_mode_ctl #(.NUM_BUS_REQ(NB)) u_pwr_mode_ctl (
      .clk(clk), .hard_rst(hard_rst), .pm_en(pm_en), .doze_req(doze_req),
      .nap_req(nap_req), .sleep_req(sleep_req), .need_qreq(need_qreq),
      .proc_alt(proc_alt), .qreq(qreq), .suspend_n(suspend_n),
      .bus_req_n(bus_req_n), .pci_hit(pci_hit), .nmi(nmi),
      .qack(qack), .mode(mode)
   );

   // {req, pm_en doze nap sleep | need alt qreq susp_n | bus1 bus0 pci nmi, mode, qack}
   localparam logic [19:0] VEC [NV] = '{
      {4'd2,  12'b1100_1011_1100, 3'd1, 1'b1},  // R2 doze entry, qreq idle
      {4'd6,  12'b1100_1011_1110, 3'd0, 1'b1},  // R6 pci hit wakes doze
      {4'd5,  12'b0100_1011_1100, 3'd0, 1'b1},  // R5 pm_en low blocks entry
      {4'd3,  12'b1010_1011_1100, 3'd0, 1'b1},  // R3 nap waits for qreq
      {4'd3,  12'b1010_1001_1100, 3'd2, 1'b0},  // R3 qreq low -> nap
      {4'd6,  12'b1000_1011_1000, 3'd0, 1'b1},  // R6 bus request wakes nap
      {4'd4,  12'b1001_0011_1100, 3'd3, 1'b0},  // R4 sleep without qreq
      {4'd7,  12'b1000_0011_1110, 3'd3, 1'b0},  // R7 pci hit ignored in sleep
      {4'd7,  12'b1000_0011_1101, 3'd0, 1'b1},  // R7 nmi wakes sleep
      {4'd5,  12'b1111_0011_1100, 3'd3, 1'b0},  // R5 sleep outranks others
      {4'd7,  12'b1111_0011_0100, 3'd0, 1'b1},  // R7 bus request wakes sleep
      {4'd5,  12'b1110_0011_1100, 3'd2, 1'b0},  // R5 nap outranks doze
      {4'd5,  12'b1111_0011_1100, 3'd2, 1'b0},  // R5 bits ignored in nap
      {4'd6,  12'b1000_0011_1101, 3'd0, 1'b1},  // R6 nmi wakes nap
      {4'd8,  12'b1000_0010_1100, 3'd4, 1'b1},  // R8 suspend entry
      {4'd8,  12'b1010_0010_1110, 3'd4, 1'b1},  // R8 suspend ignores bits, pci
      {4'd8,  12'b1000_0011_1100, 3'd0, 1'b1},  // R8 suspend exit
      {4'd8,  12'b0000_0010_1100, 3'd0, 1'b1},  // R8 needs pm_en
      {4'd10, 12'b1010_1111_1100, 3'd2, 1'b1},  // R10 alt: qreq high asserted
      {4'd9,  12'b1000_1101_1101, 3'd0, 1'b0},  // R9 alt: ack idle low
      {4'd10, 12'b1001_1101_1100, 3'd0, 1'b0},  // R10 alt: qreq low idle
      {4'd3,  12'b1001_1001_1100, 3'd3, 1'b0}   // R3 sleep with qreq asserted
   };

   task automatic apply(input logic [11:0] v);
      {pm_en, doze_req, nap_req, sleep_req, need_qreq, proc_alt, qreq,
       suspend_n, bus_req_n, pci_hit, nmi} = v;
   endtask

   task automatic check(input string tag, input logic [2:0] exp_mode,
                        input logic exp_qack);
      n_checks++;
      if (mode !== exp_mode || qack !== exp_qack) begin
         n_fail++;
         $display("FAIL %s: mode=%0d qack=%0b expected mode=%0d qack=%0b",
                  tag, mode, qack, exp_mode, exp_qack);
      end
   endtask

   initial begin
      hard_rst = 1'b1;
      apply(12'b0000_1011_1100);
      repeat (3) @(negedge clk);
      check("R1 reset", 3'd0, 1'b1);
      hard_rst = 1'b0;
      @(negedge clk);
      check("R1 idle after reset", 3'd0, 1'b1);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][15:4]);
         @(negedge clk);
         check($sformatf("R%0d row %0d", VEC[i][19:16], i),
               VEC[i][3:1], VEC[i][0]);
      end

      // R1 hard reset from sleep while suspend is asserted
      apply(12'b1001_0010_1100);
      hard_rst = 1'b1;
      @(negedge clk);
      check("R1 reset from sleep", 3'd0, 1'b1);
      @(negedge clk);
      check("R1 reset beats suspend", 3'd0, 1'b1);
      hard_rst = 1'b0;
      @(negedge clk);
      check("R8 suspend after reset", 3'd4, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule